// File: doc/BRIEF.md
# Skip-Sampled Lattice Shift Unit

This block serves one bit-field of a one-dimensional lattice of N = W·G sites, stored so that every memory word is an evenly spaced sample of the whole field. Word g holds sites g, g+G, g+2G and so on. Bit j of word g is site g + G·j. A caller asks for the field shifted by a signed amount s, as seen by site-group g. The block then reads exactly one stored word, rotates it once, and returns the G-spaced sites g + G·j, each carrying the value of site g + G·j + s. No other word is buffered or regrouped.

Some source sites fall outside the sector. The bits taken from those sites are flagged in a wrap mask. With the neighbour link enabled, the flagged bits leave on a link output, in the same bit positions they hold in the word. The bits arriving on the link input take their places. Every chip in a lockstep array makes the same choice, so together the chips form one shift that runs across sector edges. With the link disabled, the flagged bits stay in place, which gives a periodic shift within a single sector. Storage is an internal register array with a single write port. All results appear one clock after the request.

Top module: `lattice_shift_unit`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` into word `wr_addr` at the clock edge. A request in the same cycle as a write to the word it reads returns the contents from before that write.
- R2: For a request with group g and shift s, `word_addr` equals (g+s) mod G, taken as a non-negative remainder.
- R3: `rot_amt` equals floor((g+s)/G) mod W. With the link disabled, `data_out[j]` equals bit (j+rot_amt) mod W of word `word_addr`, which is the value of site (g+G·j+s) mod N.
- R4: `wrap_mask[j]` is 1 exactly when source site g+G·j+s lies below 0 or at or above N.
- R5: While the request had `mesh_en` low, `link_out` is all zeros and `data_out` is the periodic shift of R3, whatever `link_in` carries.
- R6: While the request had `mesh_en` high, `link_out[j]` carries the R3 bit where `wrap_mask[j]` is 1 and is 0 elsewhere. `data_out[j]` takes `link_in[j]` where `wrap_mask[j]` is 1 and the R3 bit elsewhere.
- R7: `out_valid` is high in the cycle after a cycle with `req_valid` high, and low otherwise. `word_addr`, `rot_amt`, `wrap_mask` and the held word change only on a request.
- R8: After reset, `out_valid`, `word_addr`, `rot_amt`, `wrap_mask` and `link_out` are zero.
- R9: A shift of zero yields `word_addr` = g, `rot_amt` = 0 and an empty wrap mask.
- R10: The shift extremes s = N−1 and s = −(N−1) follow R2 to R4, including the case in which every bit of the word wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Store `wr_data` into the word array |
| wr_addr | input | $clog2(G) | Word index to write |
| wr_data | input | W | Skip-sampled word to store |
| req_valid | input | 1 | Shift request strobe |
| req_group | input | $clog2(G) | Site-group index g |
| req_shift | input | $clog2(N)+1 | Signed shift s, magnitude below N |
| mesh_en | input | 1 | Exchange wrapped bits with the neighbour |
| link_in | input | W | Bits arriving from the opposite neighbour, by bit position |
| out_valid | output | 1 | Result of the previous cycle's request |
| word_addr | output | $clog2(G) | Stored word that was read |
| rot_amt | output | $clog2(W) | Rotation applied to that word |
| wrap_mask | output | W | Bits whose source lies outside the sector |
| link_out | output | W | Wrapped bits sent to the neighbour |
| data_out | output | W | Shifted word for the site-group |

## Verification
The assertions take for granted that every request carries a shift whose magnitude is below N, and they check this on each request. They also take for granted that `link_in` stays steady around the sampling edge, because `data_out` depends on it combinationally. The bench fills every word before it reads, draws shifts only from the range −(N−1) to N−1, and changes `link_in` only on the falling edge. The directed cases cover the zero shift, whole-word shifts, single-site shifts and both extremes. The random cases mix groups, shifts and the link setting.

// File: rtl/lattice_shift_pkg.sv
package lattice_shift_pkg;

  // Floor division for a positive divisor, correct for negative numerators.
  function automatic int lsu_floor_div(int num, int den);
    if (num >= 0) return num / den;
    return -((-num + den - 1) / den);
  endfunction

  // Non-negative remainder that pairs with lsu_floor_div.
  function automatic int lsu_mod(int num, int den);
    return num - den * lsu_floor_div(num, den);
  endfunction

  // Bit j of the word that is read comes from stored bit j+quot. It has
  // crossed the sector edge when that index falls outside the word.
  function automatic bit lsu_bit_wraps(int quot, int j, int w);
    return (j + quot < 0) || (j + quot >= w);
  endfunction

endpackage

// File: rtl/lsu_addr_calc.sv
module lsu_addr_calc
  import lattice_shift_pkg::*;
#(
  parameter int W = 8,
  parameter int G = 4,
  localparam int N  = W * G,
  localparam int AW = $clog2(G),
  localparam int RW = $clog2(W),
  localparam int SW = $clog2(N) + 1
) (
  input  logic [AW-1:0]        group_i,
  input  logic signed [SW-1:0] shift_i,
  output logic [AW-1:0]        addr_o,
  output logic [RW-1:0]        rot_o,
  output logic [W-1:0]         mask_o
);

  always_comb begin
    int tgt;
    int quot;
    tgt    = int'(group_i) + int'(shift_i);
    quot   = lsu_floor_div(tgt, G);
    addr_o = AW'(lsu_mod(tgt, G));
    rot_o  = RW'(lsu_mod(quot, W));
    for (int j = 0; j < W; j++) begin
      mask_o[j] = lsu_bit_wraps(quot, j, W);
    end
  end

endmodule

// File: rtl/lsu_word_store.sv
module lsu_word_store #(
  parameter int W = 8,
  parameter int G = 4,
  localparam int AW = $clog2(G)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] words [G];

  always_ff @(posedge clk) begin
    if (wr_en) words[wr_addr] <= wr_data;
  end

  assign rd_data = words[rd_addr];

endmodule

// File: rtl/lsu_rotator.sv
module lsu_rotator #(
  parameter int W = 8,
  localparam int RW = $clog2(W)
) (
  input  logic [W-1:0]  word_i,
  input  logic [RW-1:0] rot_i,
  output logic [W-1:0]  word_o
);

  // Output bit j takes input bit (j + rot) mod W.
  always_comb begin
    for (int j = 0; j < W; j++) begin
      int idx;
      idx = j + int'(rot_i);
      if (idx >= W) idx = idx - W;
      word_o[j] = word_i[RW'(idx)];
    end
  end

endmodule

// File: rtl/lattice_shift_unit.sv
module lattice_shift_unit #(
  parameter int W = 8,
  parameter int G = 4,
  localparam int N  = W * G,
  localparam int AW = $clog2(G),
  localparam int RW = $clog2(W),
  localparam int SW = $clog2(N) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [W-1:0]         wr_data,
  input  logic                 req_valid,
  input  logic [AW-1:0]        req_group,
  input  logic signed [SW-1:0] req_shift,
  input  logic                 mesh_en,
  input  logic [W-1:0]         link_in,
  output logic                 out_valid,
  output logic [AW-1:0]        word_addr,
  output logic [RW-1:0]        rot_amt,
  output logic [W-1:0]         wrap_mask,
  output logic [W-1:0]         link_out,
  output logic [W-1:0]         data_out
);

  // Address, rotation and wrap mask for the incoming request
  logic [AW-1:0] calc_addr;
  logic [RW-1:0] calc_rot;
  logic [W-1:0]  calc_mask;
  logic [W-1:0]  rd_word;
  logic [W-1:0]  rot_word;

  // Registered stage, named for the checker
  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic [RW-1:0] rot_q;
  logic [W-1:0]  mask_q;
  logic          mesh_q;
  logic [W-1:0]  word_q;

  lsu_addr_calc #(.W(W), .G(G)) calc_i (
    .group_i (req_group),
    .shift_i (req_shift),
    .addr_o  (calc_addr),
    .rot_o   (calc_rot),
    .mask_o  (calc_mask)
  );

  lsu_word_store #(.W(W), .G(G)) store_i (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (calc_addr),
    .rd_data (rd_word)
  );

  lsu_rotator #(.W(W)) rot_i (
    .word_i (rd_word),
    .rot_i  (calc_rot),
    .word_o (rot_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      rot_q   <= '0;
      mask_q  <= '0;
      mesh_q  <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        addr_q <= calc_addr;
        rot_q  <= calc_rot;
        mask_q <= calc_mask;
        mesh_q <= mesh_en;
        word_q <= rot_word;
      end
    end
  end

  // Neighbour exchange: wrapped bits leave in place, arrivals replace them.
  assign out_valid = valid_q;
  assign word_addr = addr_q;
  assign rot_amt   = rot_q;
  assign wrap_mask = mask_q;
  assign link_out  = mesh_q ? (word_q & mask_q) : '0;
  assign data_out  = mesh_q ? ((word_q & ~mask_q) | (link_in & mask_q)) : word_q;

endmodule

// File: rtl/lattice_shift_unit_chk.sv
module lattice_shift_unit_chk #(
  parameter int W = 8,
  parameter int G = 4,
  localparam int N  = W * G,
  localparam int AW = $clog2(G),
  localparam int RW = $clog2(W),
  localparam int SW = $clog2(N) + 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic [AW-1:0]        req_group,
  input logic signed [SW-1:0] req_shift,
  input logic                 out_valid,
  input logic [AW-1:0]        word_addr,
  input logic [RW-1:0]        rot_amt,
  input logic [W-1:0]         wrap_mask,
  input logic [W-1:0]         link_in,
  input logic [W-1:0]         link_out,
  input logic [W-1:0]         data_out,
  input logic                 mesh_q,
  input logic [W-1:0]         word_q
);

  AST_SHIFT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (int'(req_shift) > -N) && (int'(req_shift) < N));  // R10

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);  // R7

  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);  // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(word_addr) && $stable(rot_amt) && $stable(wrap_mask));  // R7

  AST_ZERO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_shift == '0) |=>
      (rot_amt == '0) && (wrap_mask == '0) && (word_addr == $past(req_group)));  // R9

  AST_LINK_QUIET: assert property (@(posedge clk) disable iff (rst)
    !mesh_q |-> link_out == '0);  // R5

  AST_LINK_ONLY_WRAPPED: assert property (@(posedge clk) disable iff (rst)
    (link_out & ~wrap_mask) == '0);  // R6

  AST_SUBST_WRAPPED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mesh_q) |-> ((data_out ^ link_in) & wrap_mask) == '0);  // R6

  AST_KEEP_UNWRAPPED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((data_out ^ word_q) & ~wrap_mask) == '0);  // R3

endmodule

bind lattice_shift_unit lattice_shift_unit_chk #(.W(W), .G(G)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_group (req_group),
  .req_shift (req_shift),
  .out_valid (out_valid),
  .word_addr (word_addr),
  .rot_amt   (rot_amt),
  .wrap_mask (wrap_mask),
  .link_in   (link_in),
  .link_out  (link_out),
  .data_out  (data_out),
  .mesh_q    (mesh_q),
  .word_q    (word_q)
);

// File: tb/lattice_shift_unit_tb_top.sv
`timescale 1ns/1ps
module lattice_shift_unit_tb_top;
  localparam int W  = 8;
  localparam int G  = 4;
  localparam int N  = W * G;
  localparam int AW = $clog2(G);
  localparam int RW = $clog2(W);
  localparam int SW = $clog2(N) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_group = '0;
  logic signed [SW-1:0] req_shift = '0;
  logic mesh_en = 1'b0;
  logic [W-1:0] link_in = '0;
  logic out_valid;
  logic [AW-1:0] word_addr;
  logic [RW-1:0] rot_amt;
  logic [W-1:0] wrap_mask, link_out, data_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [W-1:0] mem_m [G];

  always #4 clk = ~clk;

  lattice_shift_unit #(.W(W), .G(G)) dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Model works site by site: site g+G*j reads site g+G*j+s.
  task automatic model(input int g, input int s, input bit m, input logic [W-1:0] lin,
                       output int e_addr, output int e_rot, output logic [W-1:0] e_mask,
                       output logic [W-1:0] e_data, output logic [W-1:0] e_link);
    int s0;
    s0 = ((g + s) % N + N) % N;
    e_addr = s0 % G;
    e_rot  = s0 / G;
    for (int j = 0; j < W; j++) begin
      int src, sw;
      logic b;
      src = g + G * j + s;
      sw  = (src % N + N) % N;
      b   = mem_m[sw % G][sw / G];
      e_mask[j] = (src < 0) || (src >= N);
      e_link[j] = (m && e_mask[j]) ? b : 1'b0;
      e_data[j] = (m && e_mask[j]) ? lin[j] : b;
    end
  endtask

  task automatic write_word(input int a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    mem_m[a] = d;
  endtask

  task automatic request(input int g, input int s, input bit m, input logic [W-1:0] lin, input string tag);
    int ea, er;
    logic [W-1:0] em, ed, el;
    model(g, s, m, lin, ea, er, em, ed, el);
    @(negedge clk);
    req_valid = 1'b1; req_group = AW'(g); req_shift = SW'(s); mesh_en = m; link_in = lin;
    @(negedge clk);
    req_valid = 1'b0;
    check(out_valid == 1'b1, {tag, " R7 valid"}, 32'(out_valid), 1);
    check(int'(word_addr) == ea, {tag, " R2 addr"}, 32'(word_addr), 32'(ea));
    check(int'(rot_amt) == er, {tag, " R3 rot"}, 32'(rot_amt), 32'(er));
    check(wrap_mask == em, {tag, " R4 mask"}, 32'(wrap_mask), 32'(em));
    check(data_out == ed, {tag, m ? " R6 data" : " R5 data"}, 32'(data_out), 32'(ed));
    check(link_out == el, {tag, m ? " R6 link" : " R5 link"}, 32'(link_out), 32'(el));
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a0;
    logic [W-1:0] d0;
    void'($urandom(2024));
    repeat (3) @(negedge clk);
    // R8 reset state
    check(out_valid == 0 && word_addr == 0 && rot_amt == 0 && wrap_mask == 0 && link_out == 0,
          "R8 reset", {out_valid, 3'b0, 4'(word_addr), 8'(rot_amt), wrap_mask, link_out}, 0);
    rst = 1'b0;
    for (int a = 0; a < G; a++) write_word(a, W'($urandom));
    // R9 zero shift
    for (int g = 0; g < G; g++) request(g, 0, 1'b0, '1, "R9");
    // Whole-word and single-site shifts, link on and off
    request(0, G, 1'b0, '0, "R3 whole");
    request(0, -1, 1'b1, 8'hA5, "R3 right1");
    request(0, 2, 1'b1, 8'h3C, "R4 left2");
    request(G - 1, 1, 1'b0, 8'hFF, "R4 edge");
    // R10 extremes
    request(G - 1, N - 1, 1'b1, 8'h5A, "R10 max");
    request(0, -(N - 1), 1'b1, 8'hC3, "R10 min");
    request(G - 1, N - 1, 1'b0, 8'h5A, "R10 maxoff");
    // R7 hold during an idle cycle
    @(negedge clk);
    check(out_valid == 1'b0, "R7 idle valid", 32'(out_valid), 0);
    check(word_addr == AW'(G - 1 + N - 1), "R7 hold", 32'(word_addr), 32'((G - 1 + N - 1) % G));
    // R1 write and read in the same cycle return the old word
    a0 = 2'd1; d0 = ~mem_m[1];
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a0; wr_data = d0;
    req_valid = 1'b1; req_group = a0; req_shift = '0; mesh_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check(data_out == mem_m[1], "R1 old data", 32'(data_out), 32'(mem_m[1]));
    mem_m[1] = d0;
    request(1, 0, 1'b0, '0, "R1 new");
    // Random mix
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 7) == 0) write_word(int'($urandom_range(0, G - 1)), W'($urandom));
      request(int'($urandom_range(0, G - 1)), int'($urandom_range(0, 2 * N - 2)) - (N - 1),
              1'($urandom), W'($urandom), "rand");
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule